// File: doc/BRIEF.md
# Slot Hotplug Controller

This block keeps the hotplug bookkeeping for a bus of up to 32 slots that is driven by platform firmware. It holds three slot masks: which slots hold a device, which slots allow hot removal, and which slots have a removal waiting for firmware to confirm. A second per-slot flag records whether the device sitting in a slot is fixed, meaning it cannot be hot-removed.

The rest of the platform sends add, remove and coldplug requests, one per clock. Each request carries a slot number and the fixed flag of the device. Firmware reads the masks and confirms removals through a small window of four 32-bit word registers. Only full-word accesses have any effect. A hot add or hot remove pulses a strobe toward the general-purpose event block, which sets bit 1 of its status register. Every slot that a confirmed removal frees gives a pulse on the eject-done vector.

A platform reset input runs a clean-up step. It first carries out every removal still waiting, then rebuilds the removable mask from the fixed flags of the devices that remain.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, these outputs are zero: `gpe_evt`, `eject_done`, `rd_valid` and `rd_data`. `rst` leaves no slot present, no fixed flag and no removal waiting, with every slot removable.
- R2: A full-word read (`acc_be` all ones) drives `rd_valid` high and `rd_data` one cycle later, with the value the state held in the read cycle. The value depends on the offset: 0x0 returns present AND removable; 0x4 returns the waiting-removal mask; 0x8 returns 0; 0xC returns the removable mask; any other offset returns 0.
- R3: A request with `req_kind`=0 (hot add) sets the slot's present bit and stores `req_fixed` as that slot's fixed flag. It pulses `gpe_evt` in the next cycle.
- R4: A request with `req_kind`=1 (hot remove) sets the slot's waiting-removal bit and pulses `gpe_evt` in the next cycle. The present bit is left unchanged.
- R5: A request with `req_kind`=2 (coldplug) sets the present bit and the fixed flag, the same way as R3, but gives no `gpe_evt`. `req_kind`=3 has no effect.
- R6: A full-word write at offset 0x8 picks the lowest set bit of the written data. It clears that slot's waiting-removal bit. If the slot's device is not fixed, it also clears the present bit. `eject_done` shows that one slot for one cycle. Writing zero changes nothing.
- R7: An access whose `acc_be` is not all ones changes no state, and its read returns 0.
- R8: Writes at offsets other than 0x8 change no state.
- R9: A cycle with `plat_reset` high runs every waiting removal under the rule of R6. It pulses `eject_done` with those slots, clears the waiting mask and sets removable = NOT fixed. Requests and accesses in that cycle are ignored. Outside this step the removable mask never changes.
- R10: When an eject and a request fall in the same cycle, the eject is applied first and the request second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plat_reset | input | 1 | Platform reset clean-up step |
| req_valid | input | 1 | Slot request valid |
| req_kind | input | 2 | 0 hot add, 1 hot remove, 2 coldplug, 3 none |
| req_slot | input | 5 | Slot number of the request |
| req_fixed | input | 1 | Device of the request cannot be hot-removed |
| acc_valid | input | 1 | Register access valid |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_be | input | 4 | Byte enables; only all ones is accepted |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| gpe_evt | output | 1 | Pulse toward event status bit 1 |
| eject_done | output | 32 | Slots freed this cycle |

## Verification
The bench writes eject values with several bits set. A design that picks the highest bit, or frees every set bit, shows the wrong `eject_done` and a wrong waiting mask on the next read. It ejects fixed slots, where a design that drops the present bit changes the up register. It runs platform resets with waiting fixed and non-fixed slots, which catches a wrong removable rebuild or removals left behind. It also checks that coldplugs stay silent, that partial byte enables and writes to read-only offsets are ignored, and what happens when an eject and an add hit the same slot in the same cycle.

// File: rtl/slot_hp_pkg.sv
`timescale 1ns/1ps
package slot_hp_pkg;
  typedef enum logic [1:0] {
    REQ_HOT_ADD = 2'd0,
    REQ_HOT_DEL = 2'd1,
    REQ_COLD    = 2'd2,
    REQ_NONE    = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    SEL_UP, SEL_DOWN, SEL_EJECT, SEL_RMV, SEL_NONE
  } win_sel_e;

  localparam logic [3:0] OFF_UP    = 4'h0;
  localparam logic [3:0] OFF_DOWN  = 4'h4;
  localparam logic [3:0] OFF_EJECT = 4'h8;
  localparam logic [3:0] OFF_RMV   = 4'hC;
endpackage

// File: rtl/slot_hp_lowbit.sv
`timescale 1ns/1ps
module slot_hp_lowbit #(
  parameter int N = 32
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] low_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign low_o[i]    = vec_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | vec_i[i];
  end
endmodule

// File: rtl/slot_hp_decode.sv
`timescale 1ns/1ps
module slot_hp_decode
  import slot_hp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BE_W   = 4
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BE_W-1:0]   acc_be,
  input  logic              block_i,
  output logic              eject_wr_o,
  output logic              rd_en_o,
  output win_sel_e          rd_sel_o
);
  logic full_word;
  logic [3:0] off;

  assign full_word = &acc_be;
  assign off       = 4'(acc_addr);

  always_comb begin
    eject_wr_o = 1'b0;
    rd_en_o    = 1'b0;
    rd_sel_o   = SEL_NONE;
    if (acc_valid && !block_i) begin
      if (acc_write) begin
        eject_wr_o = full_word && (off == OFF_EJECT);
      end else begin
        rd_en_o = 1'b1;
        if (full_word) begin
          case (off)
            OFF_UP:    rd_sel_o = SEL_UP;
            OFF_DOWN:  rd_sel_o = SEL_DOWN;
            OFF_EJECT: rd_sel_o = SEL_EJECT;
            OFF_RMV:   rd_sel_o = SEL_RMV;
            default:   rd_sel_o = SEL_NONE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/slot_hp_masks.sv
`timescale 1ns/1ps
module slot_hp_masks
  import slot_hp_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              plat_reset,
  input  logic              eject_wr,
  input  logic [NSLOT-1:0]  eject_sel,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic              req_fixed,
  output logic [NSLOT-1:0]  present_o,
  output logic [NSLOT-1:0]  hp_en_o,
  output logic [NSLOT-1:0]  pending_o,
  output logic              gpe_evt_o,
  output logic [NSLOT-1:0]  eject_done_o
);
  logic [NSLOT-1:0] present_q, hp_en_q, pending_q, fixed_q, done_q;
  logic [NSLOT-1:0] n_present, n_hp_en, n_pending, n_fixed, n_done, gone, slot_bit;
  logic gpe_q, n_gpe;
  req_kind_e kind;

  assign kind     = req_kind_e'(req_kind);
  assign slot_bit = NSLOT'(1) << req_slot;

  always_comb begin
    n_present = present_q;
    n_hp_en   = hp_en_q;
    n_pending = pending_q;
    n_fixed   = fixed_q;
    n_done    = '0;
    n_gpe     = 1'b0;
    gone      = '0;
    if (plat_reset) begin
      gone      = pending_q & ~fixed_q;
      n_done    = pending_q;
      n_present = present_q & ~gone;
      n_fixed   = fixed_q & ~gone;
      n_pending = '0;
      n_hp_en   = ~n_fixed;
    end else begin
      if (eject_wr) begin
        n_done    = eject_sel;
        n_pending = n_pending & ~eject_sel;
        if ((eject_sel & fixed_q) == '0) begin
          n_present = n_present & ~eject_sel;
          n_fixed   = n_fixed & ~eject_sel;
        end
      end
      if (req_valid) begin
        case (kind)
          REQ_HOT_ADD, REQ_COLD: begin
            n_present = n_present | slot_bit;
            n_fixed   = req_fixed ? (n_fixed | slot_bit) : (n_fixed & ~slot_bit);
            n_gpe     = (kind == REQ_HOT_ADD);
          end
          REQ_HOT_DEL: begin
            n_pending = n_pending | slot_bit;
            n_gpe     = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= '0;
      hp_en_q   <= '1;
      pending_q <= '0;
      fixed_q   <= '0;
      done_q    <= '0;
      gpe_q     <= 1'b0;
    end else begin
      present_q <= n_present;
      hp_en_q   <= n_hp_en;
      pending_q <= n_pending;
      fixed_q   <= n_fixed;
      done_q    <= n_done;
      gpe_q     <= n_gpe;
    end
  end

  assign present_o    = present_q;
  assign hp_en_o      = hp_en_q;
  assign pending_o    = pending_q;
  assign gpe_evt_o    = gpe_q;
  assign eject_done_o = done_q;
endmodule

// File: rtl/slot_hotplug_ctrl.sv
`timescale 1ns/1ps
module slot_hotplug_ctrl
  import slot_hp_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              plat_reset,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic              req_fixed,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BE_W-1:0]   acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              gpe_evt,
  output logic [NSLOT-1:0]  eject_done
);
  logic             eject_wr, rd_en;
  win_sel_e         rd_sel;
  logic [NSLOT-1:0] eject_sel, present_m, hp_en_m, pending_m, rd_slots;
  logic [DATA_W-1:0] rd_word;
  logic             rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  slot_hp_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_be    (acc_be),
    .block_i   (plat_reset),
    .eject_wr_o(eject_wr),
    .rd_en_o   (rd_en),
    .rd_sel_o  (rd_sel)
  );

  slot_hp_lowbit #(.N(NSLOT)) u_lowbit (
    .vec_i(acc_wdata[NSLOT-1:0]),
    .low_o(eject_sel)
  );

  slot_hp_masks #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_masks (
    .clk         (clk),
    .rst         (rst),
    .plat_reset  (plat_reset),
    .eject_wr    (eject_wr),
    .eject_sel   (eject_sel),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_slot    (req_slot),
    .req_fixed   (req_fixed),
    .present_o   (present_m),
    .hp_en_o     (hp_en_m),
    .pending_o   (pending_m),
    .gpe_evt_o   (gpe_evt),
    .eject_done_o(eject_done)
  );

  always_comb begin
    case (rd_sel)
      SEL_UP:   rd_slots = present_m & hp_en_m;
      SEL_DOWN: rd_slots = pending_m;
      SEL_RMV:  rd_slots = hp_en_m;
      default:  rd_slots = '0;
    endcase
    rd_word = '0;
    rd_word[NSLOT-1:0] = rd_slots;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_data_q  <= rd_en ? rd_word : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/slot_hp_chk.sv
`timescale 1ns/1ps
module slot_hp_chk
  import slot_hp_pkg::*;
#(
  parameter int NSLOT = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             plat_reset,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             rd_valid,
  input logic             gpe_evt,
  input logic [NSLOT-1:0] eject_done,
  input logic [NSLOT-1:0] hp_en,
  input logic [NSLOT-1:0] pending
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!gpe_evt && eject_done == '0 && !rd_valid));

  p_rd_source_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write && !plat_reset));

  p_add_evt_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == REQ_HOT_ADD && !plat_reset) |=> gpe_evt);

  p_del_evt_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == REQ_HOT_DEL && !plat_reset) |=> (gpe_evt && pending != '0));

  p_cold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == REQ_COLD) |=> !gpe_evt);

  p_eject_single_r6: assert property (@(posedge clk) disable iff (rst)
    !plat_reset |=> $onehot0(eject_done));

  p_plat_clear_r9: assert property (@(posedge clk) disable iff (rst)
    plat_reset |=> (pending == '0 && !gpe_evt));

  p_hpen_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !plat_reset |=> $stable(hp_en));
endmodule

bind slot_hotplug_ctrl slot_hp_chk #(.NSLOT(NSLOT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .plat_reset(plat_reset),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .rd_valid  (rd_valid),
  .gpe_evt   (gpe_evt),
  .eject_done(eject_done),
  .hp_en     (hp_en_m),
  .pending   (pending_m)
);

// File: tb/slot_hotplug_ctrl_bench.sv
`timescale 1ns/1ps
module slot_hotplug_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, plat_reset, req_valid, req_fixed, acc_valid, acc_write;
  logic [1:0]  req_kind;
  logic [4:0]  req_slot;
  logic [3:0]  acc_addr, acc_be;
  logic [31:0] acc_wdata;
  logic        rd_valid, gpe_evt;
  logic [31:0] rd_data, eject_done;

  slot_hotplug_ctrl u_slot_hotplug_ctrl (
    .clk(clk), .rst(rst), .plat_reset(plat_reset), .req_valid(req_valid),
    .req_kind(req_kind), .req_slot(req_slot), .req_fixed(req_fixed),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .gpe_evt(gpe_evt), .eject_done(eject_done)
  );

  logic [31:0] m_pres, m_hp, m_pend, m_fix;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'h1 << i;
    return 32'h0;
  endfunction

  function automatic logic [31:0] win_value(input logic [3:0] a);
    case (a)
      4'h0: return m_pres & m_hp;
      4'h4: return m_pend;
      4'hC: return m_hp;
      default: return 32'h0;
    endcase
  endfunction

  // Drives one cycle right after a falling edge, checks at the next one.
  task automatic cyc(input bit pr, input bit rv, input logic [1:0] rk, input logic [4:0] rs,
                     input bit rf, input bit av, input bit aw, input logic [3:0] ad,
                     input logic [3:0] be, input logic [31:0] wd, input string rtag);
    logic [31:0] e_done, e_rd, b, gone, s;
    bit e_gpe, e_rv;
    string gtag;
    plat_reset = pr; req_valid = rv; req_kind = rk; req_slot = rs; req_fixed = rf;
    acc_valid = av; acc_write = aw; acc_addr = ad; acc_be = be; acc_wdata = wd;
    e_done = 0; e_gpe = 0; e_rv = 0; e_rd = 0;
    b = 32'h1 << rs;
    gtag = (rk == 2'd0) ? "R3" : (rk == 2'd1) ? "R4" : "R5";
    if (pr) begin
      gone   = m_pend & ~m_fix;
      e_done = m_pend;
      m_pres = m_pres & ~gone;
      m_fix  = m_fix & ~gone;
      m_pend = 0;
      m_hp   = ~m_fix;
    end else begin
      if (av && !aw) begin
        e_rv = 1;
        e_rd = (be == 4'hF) ? win_value(ad) : 32'h0;
      end
      if (av && aw && be == 4'hF && ad == 4'h8) begin
        s = lowest(wd);
        e_done = s;
        m_pend = m_pend & ~s;
        if ((s & m_fix) == 0) begin
          m_pres = m_pres & ~s;
          m_fix  = m_fix & ~s;
        end
      end
      if (rv) begin
        case (rk)
          2'd0, 2'd2: begin
            m_pres = m_pres | b;
            m_fix  = rf ? (m_fix | b) : (m_fix & ~b);
            e_gpe  = (rk == 2'd0);
          end
          2'd1: begin m_pend = m_pend | b; e_gpe = 1; end
          default: ;
        endcase
      end
    end
    @(negedge clk);
    chk(gtag, {31'h0, gpe_evt}, {31'h0, e_gpe});
    chk(pr ? "R9" : "R6", eject_done, e_done);
    chk(rtag, {31'h0, rd_valid}, {31'h0, e_rv});
    chk(rtag, rd_data, e_rd);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 0, a, 4'hF, 0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 1, a, 4'hF, d, tag);
  endtask
  task automatic req(input logic [1:0] k, input logic [4:0] s, input bit f);
    cyc(0, 1, k, s, f, 0, 0, 0, 0, 0, "R2");
  endtask
  task automatic read_all(input string tag);
    rd(4'h0, tag); rd(4'h4, tag); rd(4'h8, tag); rd(4'hC, tag);
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; plat_reset = 0; req_valid = 0; req_kind = 0; req_slot = 0; req_fixed = 0;
    acc_valid = 0; acc_write = 0; acc_addr = 0; acc_be = 0; acc_wdata = 0;
    m_pres = 0; m_hp = 32'hFFFF_FFFF; m_pend = 0; m_fix = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", {31'h0, gpe_evt}, 32'h0);
    chk("R1", eject_done, 32'h0);
    chk("R1", {31'h0, rd_valid}, 32'h0);
    chk("R1", rd_data, 32'h0);
    read_all("R1");

    // directed corner cases
    req(2'd2, 5'd3, 0);            // R5 coldplug, silent
    req(2'd2, 5'd0, 1);            // R5 fixed coldplug
    req(2'd0, 5'd31, 0);           // R3 hot add
    req(2'd3, 5'd7, 0);            // R5 kind 3 no effect
    read_all("R2");
    req(2'd1, 5'd3, 0);            // R4 hot remove
    rd(4'h4, "R4");
    wr(4'h8, 32'h0000_0009, "R6"); // lowest = slot 0, fixed stays present
    rd(4'h0, "R6");
    wr(4'h8, 32'h0000_0008, "R6"); // slot 3 removed
    read_all("R6");
    wr(4'h8, 32'h0, "R6");         // zero write: nothing
    rd(4'h0, "R6");
    wr(4'h0, 32'h0, "R8");         // write to up ignored
    wr(4'h4, 32'hFFFF_FFFF, "R8");
    wr(4'hC, 32'h0, "R8");
    read_all("R8");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'h8, 4'h3, 32'h8000_0000, "R7"); // partial write ignored
    cyc(0, 0, 0, 0, 0, 1, 0, 4'hC, 4'h7, 0, "R7");             // partial read is 0
    rd(4'h0, "R7");
    rd(4'h6, "R2");                // misaligned offset reads 0
    // same-cycle eject and add on slot 31
    cyc(0, 1, 2'd0, 5'd31, 1, 1, 1, 4'h8, 4'hF, 32'h8000_0000, "R10");
    rd(4'h0, "R10");
    // platform reset with fixed and non-fixed slots waiting
    req(2'd2, 5'd5, 1);
    req(2'd2, 5'd9, 0);
    req(2'd1, 5'd5, 0);
    req(2'd1, 5'd9, 0);
    cyc(1, 1, 2'd0, 5'd12, 0, 1, 1, 4'h8, 4'hF, 32'h1, "R9");
    read_all("R9");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit pr, rv, rf, av, aw;
      logic [1:0] rk;
      logic [4:0] rs;
      logic [3:0] ad, be;
      logic [31:0] wd;
      pr = ($urandom % 150) == 0;
      rv = ($urandom % 2) == 0;
      rk = 2'($urandom % 4);
      rs = 5'($urandom % 32);
      rf = ($urandom % 4) == 0;
      av = ($urandom % 5) < 2;
      aw = ($urandom % 2) == 0;
      ad = (($urandom % 6) == 0) ? 4'($urandom) : 4'(($urandom % 4) * 4);
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      case ($urandom % 3)
        0: wd = $urandom;
        1: wd = (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32));
        default: wd = m_pend;
      endcase
      cyc(pr, rv, rk, rs, rf, av, aw, ad, be, wd, (be == 4'hF) ? "R2" : "R7");
    end
    read_all("R2");
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule